// File: doc/BRIEF.md
# SPI Byte FIFO Pair with Threshold Interrupts

This block buffers the byte stream between a processor-side register interface and a serial shifting engine. Software pushes transmit bytes by writing a data register, and pops received bytes by reading another. The shifting engine sits outside the block. It takes transmit bytes through a pop strobe and delivers received bytes through a push strobe. Both FIFOs hold `DEPTH` entries of eight bits each.

A packed level word reports both live occupancies at once. Three sticky flags are cleared by writing ones to them. They record three events: the receive side has filled to three quarters, the transmit side has drained to a quarter, and the engine has signalled the end of a transfer. A separate enable register gates the flags onto a single interrupt line. Each FIFO can be emptied through a self-clearing control bit.

Top module: `spi_fifo_pair`

## Requirements
- R1: After reset both FIFOs are empty, the status, enable and control registers read zero, `tx_empty_o` is high and `irq_o` is low.
- R2: Register word addresses: 0 is receive data (a read pops), 1 is transmit data (a write pushes `wdata[7:0]`), 2 is FIFO control, 3 is interrupt enable, 4 is interrupt status, and 5 is the level word. Each FIFO returns bytes in the order they were pushed. The level word carries the receive count at bits 6:0 and the transmit count at bits 22:16.
- R3: A push into a FIFO that holds `DEPTH` bytes is dropped and leaves the count at `DEPTH`. `rx_full_o` is high exactly while the receive count equals `DEPTH`.
- R4: A pop from an empty FIFO returns zero and leaves the count at zero. While the transmit FIFO is empty, `tx_data_o` reads zero.
- R5: Status bit 4 sets on the clock edge that follows any cycle in which the receive count is at least `DEPTH*3/4`.
- R6: Status bit 12 sets on the clock edge that follows any cycle in which the transmit count is at most `DEPTH/4`.
- R7: Status bit 16 sets on the clock edge that follows a cycle with `xfer_done_i` high.
- R8: Writing status with a one in a flag position clears that flag at the next edge, and a clear wins over a set in the same cycle. Writing all ones clears every flag. A flag whose condition still holds sets again one edge later.
- R9: A flag latches whether or not it is enabled. The enable register keeps only bits 4, 12 and 16. `irq_o` is high exactly when some status bit and the matching enable bit are both one.
- R10: Writing control bit 0 empties the transmit FIFO and writing control bit 1 empties the receive FIFO, both at the next edge. Each bit reads back as one for one cycle after the write and then clears itself. A push into that FIFO in the same cycle as the clear is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops on the receive data address) |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| tx_pop_i | input | 1 | Engine takes the head transmit byte |
| tx_data_o | output | 8 | Head transmit byte, zero when empty |
| tx_empty_o | output | 1 | Transmit FIFO empty |
| rx_push_i | input | 1 | Engine delivers a received byte |
| rx_data_i | input | 8 | Received byte |
| rx_full_o | output | 1 | Receive FIFO full |
| xfer_done_i | input | 1 | Transfer-complete pulse from the engine |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
The bench builds the block with `DEPTH` = 16, so the thresholds fall at 12 and 4. With that depth the full, overflow and threshold crossings each take a handful of cycles, and a long run of mixed random traffic can fill and drain both FIFOs many times. The level fields keep their fixed bit offsets at every depth. The receive-full boundary, the transmit-quarter boundary and the re-set-after-clear behaviour are therefore covered in the same way they would be at the default depth of 64.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int DATA_W = 8;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 3;
  localparam int NFLAG  = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_RXDATA  = 3'd0,
    A_TXDATA  = 3'd1,
    A_CTRL    = 3'd2,
    A_IRQ_EN  = 3'd3,
    A_IRQ_STA = 3'd4,
    A_LEVEL   = 3'd5
  } reg_addr_e;

  // flag index inside the compact flag vector
  localparam int F_RX_HI = 0;
  localparam int F_TX_LO = 1;
  localparam int F_DONE  = 2;

  // bit positions in the enable and status words
  localparam int B_RX_HI = 4;
  localparam int B_TX_LO = 12;
  localparam int B_DONE  = 16;

  localparam int LVL_RX_LSB  = 0;
  localparam int LVL_TX_LSB  = 16;
  localparam int CTRL_TX_RST = 0;
  localparam int CTRL_RX_RST = 1;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     dout_o,
  output logic [CNT_W-1:0] count_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             push_ok, pop_ok;

  assign push_ok = push_i && (count < CNT_W'(DEPTH)) && !flush_i;
  assign pop_ok  = pop_i && (count != '0) && !flush_i;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign dout_o  = (count == '0) ? '0 : mem[rd_ptr];
  assign count_o = count;
endmodule

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int NUM = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NUM-1:0] set_i,
  input  logic [NUM-1:0] clr_i,
  input  logic           en_wr_i,
  input  logic [NUM-1:0] en_i,
  output logic [NUM-1:0] sta_o,
  output logic [NUM-1:0] en_o,
  output logic           irq_o
);
  logic [NUM-1:0] sta_q, en_q;

  for (genvar g = 0; g < NUM; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sta_q[g] <= 1'b0;
        en_q[g]  <= 1'b0;
      end else begin
        // clear wins; a live condition re-sets on the next edge
        if (clr_i[g])      sta_q[g] <= 1'b0;
        else if (set_i[g]) sta_q[g] <= 1'b1;
        if (en_wr_i)       en_q[g]  <= en_i[g];
      end
    end
  end

  assign sta_o = sta_q;
  assign en_o  = en_q;
  assign irq_o = |(sta_q & en_q);
endmodule

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              tx_pop_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_empty_o,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              rx_full_o,
  input  logic              xfer_done_i,
  output logic              irq_o
);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int RX_THR = DEPTH * 3 / 4;
  localparam int TX_THR = DEPTH / 4;

  logic wr_tx, rd_rx, wr_ctrl, wr_en, wr_sta;
  assign wr_tx   = reg_wr_i && (reg_addr_i == A_TXDATA);
  assign rd_rx   = reg_rd_i && (reg_addr_i == A_RXDATA);
  assign wr_ctrl = reg_wr_i && (reg_addr_i == A_CTRL);
  assign wr_en   = reg_wr_i && (reg_addr_i == A_IRQ_EN);
  assign wr_sta  = reg_wr_i && (reg_addr_i == A_IRQ_STA);

  // self-clearing FIFO reset pulses
  logic [1:0] flush_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flush_q <= '0;
    else if (wr_ctrl) flush_q <= {reg_wdata_i[CTRL_RX_RST], reg_wdata_i[CTRL_TX_RST]};
    else              flush_q <= '0;
  end

  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic [DATA_W-1:0] rx_head;

  byte_fifo #(.DEPTH(DEPTH), .W(DATA_W)) i_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_q[0]),
    .push_i  (wr_tx),
    .din_i   (reg_wdata_i[DATA_W-1:0]),
    .pop_i   (tx_pop_i),
    .dout_o  (tx_data_o),
    .count_o (tx_cnt)
  );

  byte_fifo #(.DEPTH(DEPTH), .W(DATA_W)) i_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_q[1]),
    .push_i  (rx_push_i),
    .din_i   (rx_data_i),
    .pop_i   (rd_rx),
    .dout_o  (rx_head),
    .count_o (rx_cnt)
  );

  assign tx_empty_o = (tx_cnt == '0);
  assign rx_full_o  = (rx_cnt == CNT_W'(DEPTH));

  // register-word bits to compact flag vector
  logic [NFLAG-1:0] flag_set, flag_clr, en_new, sta_flags, en_flags;
  always_comb begin
    flag_set          = '0;
    flag_set[F_RX_HI] = (rx_cnt >= CNT_W'(RX_THR));
    flag_set[F_TX_LO] = (tx_cnt <= CNT_W'(TX_THR));
    flag_set[F_DONE]  = xfer_done_i;
    flag_clr          = '0;
    if (wr_sta) begin
      flag_clr[F_RX_HI] = reg_wdata_i[B_RX_HI];
      flag_clr[F_TX_LO] = reg_wdata_i[B_TX_LO];
      flag_clr[F_DONE]  = reg_wdata_i[B_DONE];
    end
    en_new = {reg_wdata_i[B_DONE], reg_wdata_i[B_TX_LO], reg_wdata_i[B_RX_HI]};
  end

  irq_flags #(.NUM(NFLAG)) i_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (flag_set),
    .clr_i   (flag_clr),
    .en_wr_i (wr_en),
    .en_i    (en_new),
    .sta_o   (sta_flags),
    .en_o    (en_flags),
    .irq_o   (irq_o)
  );

  function automatic logic [REG_W-1:0] spread(input logic [NFLAG-1:0] f);
    logic [REG_W-1:0] w;
    w          = '0;
    w[B_RX_HI] = f[F_RX_HI];
    w[B_TX_LO] = f[F_TX_LO];
    w[B_DONE]  = f[F_DONE];
    return w;
  endfunction

  logic [REG_W-1:0] level_w;
  always_comb begin
    level_w = '0;
    level_w[LVL_RX_LSB +: CNT_W] = rx_cnt;
    level_w[LVL_TX_LSB +: CNT_W] = tx_cnt;
  end

  always_comb begin
    unique case (reg_addr_i)
      A_RXDATA:  reg_rdata_o = {{(REG_W-DATA_W){1'b0}}, rx_head};
      A_CTRL:    reg_rdata_o = {{(REG_W-2){1'b0}}, flush_q};
      A_IRQ_EN:  reg_rdata_o = spread(en_flags);
      A_IRQ_STA: reg_rdata_o = spread(sta_flags);
      A_LEVEL:   reg_rdata_o = level_w;
      default:   reg_rdata_o = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i;
endmodule

// File: rtl/spi_fifo_pair_chk.sv
module spi_fifo_pair_chk
  import spi_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int RX_THR = DEPTH * 3 / 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [REG_W-1:0]  reg_wdata_i,
  input logic              xfer_done_i,
  input logic [DATA_W-1:0] tx_data_o,
  input logic [CNT_W-1:0]  tx_cnt_i,
  input logic [CNT_W-1:0]  rx_cnt_i,
  input logic [NFLAG-1:0]  sta_i,
  input logic [1:0]        flush_i
);
  logic wr_sta;
  assign wr_sta = reg_wr_i && (reg_addr_i == A_IRQ_STA);

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_cnt_i <= CNT_W'(DEPTH)) && (tx_cnt_i <= CNT_W'(DEPTH)));

  p_empty_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_cnt_i == '0) |-> (tx_data_o == '0));

  p_rx_hi_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rx_cnt_i >= CNT_W'(RX_THR)) && !(wr_sta && reg_wdata_i[B_RX_HI])) |=> sta_i[F_RX_HI]);

  p_done_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_done_i && !(wr_sta && reg_wdata_i[B_DONE])) |=> sta_i[F_DONE]);

  p_w1c_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sta && reg_wdata_i[B_TX_LO]) |=> !sta_i[F_TX_LO]);

  p_tx_flush_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i[0] |=> (tx_cnt_i == '0));

  p_rx_flush_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i[1] |=> (rx_cnt_i == '0));
endmodule

bind spi_fifo_pair spi_fifo_pair_chk #(.DEPTH(DEPTH)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .xfer_done_i (xfer_done_i),
  .tx_data_o   (tx_data_o),
  .tx_cnt_i    (tx_cnt),
  .rx_cnt_i    (rx_cnt),
  .sta_i       (sta_flags),
  .flush_i     (flush_q)
);

// File: tb/test_spi_fifo_pair.sv
module test_spi_fifo_pair;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int RX_THR     = DEPTH * 3 / 4;
  localparam int TX_THR     = DEPTH / 4;
  localparam logic [31:0] MASK = 32'h0001_1010;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        tx_pop_i = 1'b0;
  logic [7:0]  tx_data_o;
  logic        tx_empty_o;
  logic        rx_push_i = 1'b0;
  logic [7:0]  rx_data_i = '0;
  logic        rx_full_o;
  logic        xfer_done_i = 1'b0;
  logic        irq_o;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  spi_fifo_pair #(.DEPTH(DEPTH)) i_spi_fifo_pair (
    .clk_i, .rst_ni, .reg_wr_i, .reg_rd_i, .reg_addr_i, .reg_wdata_i,
    .reg_rdata_o, .tx_pop_i, .tx_data_o, .tx_empty_o, .rx_push_i,
    .rx_data_i, .rx_full_o, .xfer_done_i, .irq_o
  );

  int tests = 0, fails = 0;
  string cur_req = "R2";

  logic [7:0]  txq[$], rxq[$];
  logic [31:0] m_sta = '0, m_en = '0;
  logic [1:0]  m_flush = '0;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rdata(logic [2:0] a);
    case (a)
      3'd0: return (rxq.size() > 0) ? {24'h0, rxq[0]} : 32'h0;
      3'd2: return {30'h0, m_flush};
      3'd3: return m_en;
      3'd4: return m_sta;
      3'd5: return 32'(rxq.size()) | (32'(txq.size()) << 16);
      default: return 32'h0;
    endcase
  endfunction

  // compare this cycle, advance the model, then move to the next falling edge
  task automatic step();
    int ntx, nrx;
    logic [31:0] clr, set;
    #1;
    check("R2", "tx_data_o", 32'(tx_data_o), (txq.size() > 0) ? 32'(txq[0]) : 32'h0);
    check("R4", "tx_empty_o", 32'(tx_empty_o), 32'(txq.size() == 0));
    check("R3", "rx_full_o", 32'(rx_full_o), 32'(rxq.size() == DEPTH));
    check("R9", "irq_o", 32'(irq_o), 32'(|(m_sta & m_en)));
    if (reg_rd_i) check(cur_req, "reg_rdata_o", reg_rdata_o, exp_rdata(reg_addr_i));
    ntx = txq.size();
    nrx = rxq.size();
    clr = (reg_wr_i && reg_addr_i == 3'd4) ? reg_wdata_i : 32'h0;
    set = ((nrx >= RX_THR) ? 32'h10 : 32'h0) | ((ntx <= TX_THR) ? 32'h1000 : 32'h0)
        | (xfer_done_i ? 32'h1_0000 : 32'h0);
    m_sta = (m_sta | set) & ~clr & MASK;
    if (reg_wr_i && reg_addr_i == 3'd3) m_en = reg_wdata_i & MASK;
    if (m_flush[0]) txq.delete();
    else begin
      if (tx_pop_i && ntx > 0) void'(txq.pop_front());
      if (reg_wr_i && reg_addr_i == 3'd1 && ntx < DEPTH) txq.push_back(reg_wdata_i[7:0]);
    end
    if (m_flush[1]) rxq.delete();
    else begin
      if (reg_rd_i && reg_addr_i == 3'd0 && nrx > 0) void'(rxq.pop_front());
      if (rx_push_i && nrx < DEPTH) rxq.push_back(rx_data_i);
    end
    m_flush = (reg_wr_i && reg_addr_i == 3'd2) ? reg_wdata_i[1:0] : 2'b00;
    @(posedge clk_i);
    @(negedge clk_i);
    reg_wr_i = 0; reg_rd_i = 0; reg_addr_i = 0; reg_wdata_i = 0;
    tx_pop_i = 0; rx_push_i = 0; rx_data_i = 0; xfer_done_i = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
    step();
  endtask

  task automatic rd(logic [2:0] a, string req);
    cur_req = req;
    reg_rd_i = 1; reg_addr_i = a;
    step();
  endtask

  // read with an expected value taken straight from the requirement
  task automatic rd_exp(logic [2:0] a, logic [31:0] mask, logic [31:0] exp, string req, string what);
    reg_rd_i = 1; reg_addr_i = a;
    #1 check(req, what, reg_rdata_o & mask, exp);
    cur_req = req;
    step();
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog all-reqs actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1: reset state seen while reset is held
    repeat (3) @(negedge clk_i);
    reg_addr_i = 3'd4;
    #1;
    check("R1", "status in reset", reg_rdata_o, 32'h0);
    check("R1", "tx_empty_o in reset", 32'(tx_empty_o), 32'h1);
    check("R1", "irq_o in reset", 32'(irq_o), 32'h0);
    rst_ni = 1;
    reg_addr_i = 0;
    rd_exp(3'd5, 32'hffff_ffff, 32'h0, "R1", "level after reset");
    rd_exp(3'd3, 32'hffff_ffff, 32'h0, "R1", "enable after reset");
    rd_exp(3'd2, 32'hffff_ffff, 32'h0, "R1", "control after reset");

    // R6: transmit count of zero keeps the low-water flag set
    rd_exp(3'd4, 32'h1000, 32'h1000, "R6", "tx low flag");

    // R2 R4: transmit ordering, and a pop beyond the last byte
    for (int i = 0; i < 5; i++) wr(3'd1, 32'hA0 + 32'(i));
    rd(3'd5, "R2");
    for (int i = 0; i < 6; i++) begin tx_pop_i = 1; step(); end
    rd_exp(3'd5, 32'h007f_0000, 32'h0, "R4", "tx count after empty pop");

    // R3 R5: fill receive side past full
    for (int i = 0; i < DEPTH + 3; i++) begin
      rx_push_i = 1; rx_data_i = 8'h30 + 8'(i); step();
      if (i == RX_THR - 2) rd_exp(3'd4, 32'h10, 32'h0, "R5", "rx high flag before threshold");
    end
    rd_exp(3'd5, 32'h7f, 32'(DEPTH), "R3", "rx count saturates");
    rd_exp(3'd4, 32'h10, 32'h10, "R5", "rx high flag");
    rd_exp(3'd0, 32'hff, 32'h30, "R2", "first rx byte");
    for (int i = 1; i < DEPTH; i++) rd(3'd0, "R2");
    rd_exp(3'd0, 32'hffff_ffff, 32'h0, "R4", "empty rx pop");
    rd_exp(3'd5, 32'h7f, 32'h0, "R4", "rx count after empty pop");

    // R8: clear all; rx flag stays clear, tx flag returns
    wr(3'd4, 32'hffff_ffff);
    rd_exp(3'd4, 32'hffff_ffff, 32'h0, "R8", "status right after clear");
    rd_exp(3'd4, 32'hffff_ffff, 32'h1000, "R8", "tx flag sets again");

    // R9: latched but masked, then enabled
    check("R9", "irq masked", 32'(irq_o), 32'h0);
    wr(3'd3, 32'hffff_ffff);
    rd_exp(3'd3, 32'hffff_ffff, MASK, "R9", "enable keeps three bits");
    wr(3'd3, 32'h0001_0000);
    rd(3'd4, "R9");
    xfer_done_i = 1; step();
    rd_exp(3'd4, 32'h1_0000, 32'h1_0000, "R7", "done flag");
    #1 check("R9", "irq with done enabled", 32'(irq_o), 32'h1);
    wr(3'd4, 32'h1_0000);
    rd_exp(3'd4, 32'h1_0000, 32'h0, "R8", "done flag cleared");

    // R10: transmit reset, push in the flush cycle is dropped
    for (int i = 0; i < 8; i++) wr(3'd1, 32'h50 + 32'(i));
    wr(3'd2, 32'h1);
    rd_exp(3'd2, 32'h3, 32'h1, "R10", "tx reset bit readback");
    rd_exp(3'd2, 32'h3, 32'h0, "R10", "tx reset bit self clears");
    wr(3'd1, 32'h77);
    wr(3'd2, 32'h1);
    wr(3'd1, 32'h78);
    rd_exp(3'd5, 32'h007f_0000, 32'h0, "R10", "tx count after reset");
    for (int i = 0; i < 6; i++) begin rx_push_i = 1; rx_data_i = 8'(i); step(); end
    wr(3'd2, 32'h2);
    rd(3'd2, "R10");
    rd_exp(3'd5, 32'h7f, 32'h0, "R10", "rx count after reset");

    // R2: mixed random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 7));
      if (r < 3) begin reg_wr_i = 1; reg_addr_i = 3'd1; reg_wdata_i = 32'($urandom_range(0, 255)); end
      else if (r < 6) begin reg_rd_i = 1; reg_addr_i = (r == 5) ? 3'd5 : 3'd0; cur_req = "R2"; end
      else if (r == 6) begin reg_rd_i = 1; reg_addr_i = 3'd4; cur_req = "R8"; end
      else begin reg_wr_i = 1; reg_addr_i = 3'd4; reg_wdata_i = $urandom; end
      tx_pop_i    = ($urandom_range(0, 2) == 0);
      rx_push_i   = ($urandom_range(0, 2) != 0);
      rx_data_i   = 8'($urandom_range(0, 255));
      xfer_done_i = ($urandom_range(0, 31) == 0);
      step();
    end
    finish_run();
  end
endmodule